// File: doc/BRIEF.md
# Supply-fail write-protect sequencer

This block sits between a host and a battery-backed static memory. It decides when the memory may be accessed and which energy source feeds the array. Two external comparators each supply a digital flag. One says the supply is above the write-protect trip point: 4.50 to 4.75 V on the tight-tolerance build, 4.25 to 4.5 V on the loose one. The other says the supply is above the roughly 3 V switchover level. Both flags are synchronised and debounced. A five-state sequencer then forces the host's strobes inactive and floats the data outputs whenever the supply is not trusted. When the supply sags below switchover, the sequencer connects the backup cell. When the supply comes back, it holds protection for a long recovery window before normal operation resumes.

A sticky arming register keeps the backup cell disconnected from the factory until the supply first rises above the trip point. An ordinary power-on reset leaves that register untouched. Only a dedicated factory-reset input clears it again. All delays are counted in clock ticks. The default recovery window is 125 ms at 125 MHz.

Top module: `supply_fail_guard`

## Requirements
- R1: Each supply flag passes through two synchronising flops. A new level is accepted only after the synchronised flag has differed from the accepted level for FILT_TICKS consecutive clocks. Shorter pulses leave `mode_o` unchanged.
- R2: `mode_o` is encoded as 0 sealed, 1 normal, 2 protect, 3 backup, 4 recover. A factory reset gives the following state: mode 0, `armed_o` low, `bat_sel_o` low, all memory strobes high and `dq_hiz_o` high.
- R3: In every mode other than normal, the following outputs are all high whatever the host drives: `mem_ce_n_o`, `mem_we_n_o`, `mem_oe_n_o` and `dq_hiz_o`.
- R4: In normal mode, each memory strobe equals the matching host strobe. `dq_hiz_o` is low only when host chip enable and output enable are low and host write enable is high.
- R5: A trip flag that falls during normal mode, and stays low, moves the block to protect with strobes forced inactive. This happens no later than the (FILT_TICKS+3)-th rising clock edge after the input change.
- R6: In protect with the switchover flag low, the block enters backup and raises `bat_sel_o`. When the switchover flag returns, it goes back to protect and `bat_sel_o` falls.
- R7: In protect with the trip flag high, the block enters recover. It stays there for exactly RECOVER_TICKS clocks and then enters normal.
- R8: An accepted trip-flag drop during recover returns the block to protect. The next recovery starts its count from zero.
- R9: In sealed mode, `bat_sel_o` stays low even while the switchover flag is low. The first accepted high trip flag sets `armed_o` and moves the block to recover.
- R10: `armed_o` survives the ordinary reset `rst`. After `rst` the mode is protect if armed and sealed if not. `factory_rst` clears `armed_o` and returns the block to sealed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Ordinary synchronous power-on reset, active high |
| factory_rst | input | 1 | Synchronous factory reset; also clears the arming register |
| vtrip_ok_i | input | 1 | Supply above write-protect trip point (asynchronous) |
| vsw_ok_i | input | 1 | Supply above backup switchover level (asynchronous) |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| mem_ce_n_o | output | 1 | Gated chip enable to memory, active low |
| mem_we_n_o | output | 1 | Gated write enable to memory, active low |
| mem_oe_n_o | output | 1 | Gated output enable to memory, active low |
| dq_hiz_o | output | 1 | High: data output drivers are floated |
| bat_sel_o | output | 1 | High: backup cell feeds the array; low: main supply |
| armed_o | output | 1 | Backup cell has been armed (seal broken) |
| mode_o | output | 3 | Current sequencer mode |

## Verification
On every clock the bound checker confirms the following. Any non-normal mode has all strobes held inactive and the data outputs floated. An unarmed block never selects the backup cell. The backup cell is only connected after a low switchover flag. A trip drop in normal or recover leaves that mode on the next clock. Each entry to normal is preceded by exactly RECOVER_TICKS clocks of recover. The arming register never falls without a factory reset. Two things show only in the bench's scenarios: glitch filtering and the exact trip-to-protect latency. The bench's cycle-by-cycle model also covers pass-through of host strobes in normal mode and arming surviving an ordinary reset.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_SEALED  = 3'd0,
        PS_NORMAL  = 3'd1,
        PS_PROTECT = 3'd2,
        PS_BACKUP  = 3'd3,
        PS_RECOVER = 3'd4
    } pwr_state_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_TRIP = 0;
    localparam int FLAG_SW   = 1;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } strobes_t;

    function automatic logic is_guarded(pwr_state_e s);
        return s != PS_NORMAL;
    endfunction

    function automatic logic host_reads(strobes_t h);
        return !h.ce_n && !h.oe_n && h.we_n;
    endfunction

endpackage

// File: rtl/pwrseq_lvl_filter.sv
`timescale 1ns/1ps
module pwrseq_lvl_filter #(
    parameter int WIDTH      = 2,
    parameter int FILT_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] clean_o
);
    localparam int CW = (FILT_TICKS < 2) ? 1 : $clog2(FILT_TICKS + 1);

    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        logic [1:0]    sync_q;
        logic          stable_q;
        logic [CW-1:0] run_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q   <= '0;
                stable_q <= 1'b0;
                run_q    <= '0;
            end else begin
                sync_q <= {sync_q[0], raw_i[g]};
                if (sync_q[1] == stable_q) begin
                    run_q <= '0;
                end else if (run_q == CW'(FILT_TICKS - 1)) begin
                    stable_q <= sync_q[1];
                    run_q    <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end

        assign clean_o[g] = stable_q;
    end

endmodule

// File: rtl/pwrseq_seal.sv
`timescale 1ns/1ps
module pwrseq_seal (
    input  logic clk,
    input  logic factory_rst,
    input  logic arm_i,
    output logic armed_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (factory_rst) begin
            armed_q <= 1'b0;
        end else if (arm_i) begin
            armed_q <= 1'b1;
        end
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/pwrseq_fsm.sv
`timescale 1ns/1ps
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int RECOVER_TICKS = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       factory_rst,
    input  logic       trip_ok_i,
    input  logic       sw_ok_i,
    input  logic       armed_i,
    output pwr_state_e state_o,
    output logic       arm_o,
    output logic       bat_sel_o
);
    localparam int RW = (RECOVER_TICKS < 2) ? 1 : $clog2(RECOVER_TICKS + 1);

    pwr_state_e    state_q;
    pwr_state_e    state_d;
    logic [RW-1:0] rec_q;
    logic          rec_done;

    assign rec_done = (rec_q == RW'(RECOVER_TICKS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_SEALED:  if (trip_ok_i) state_d = PS_RECOVER;
            PS_NORMAL:  if (!trip_ok_i) state_d = PS_PROTECT;
            PS_PROTECT: begin
                if (!sw_ok_i)      state_d = PS_BACKUP;
                else if (trip_ok_i) state_d = PS_RECOVER;
            end
            PS_BACKUP:  if (sw_ok_i) state_d = PS_PROTECT;
            PS_RECOVER: begin
                if (!trip_ok_i)    state_d = PS_PROTECT;
                else if (rec_done) state_d = PS_NORMAL;
            end
            default:    state_d = PS_PROTECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (factory_rst) begin
            state_q <= PS_SEALED;
            rec_q   <= '0;
        end else if (rst) begin
            state_q <= armed_i ? PS_PROTECT : PS_SEALED;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_RECOVER && state_d == PS_RECOVER) begin
                rec_q <= rec_q + 1'b1;
            end else begin
                rec_q <= '0;
            end
        end
    end

    assign state_o   = state_q;
    assign arm_o     = (state_q == PS_SEALED) && trip_ok_i && !rst;
    assign bat_sel_o = (state_q == PS_BACKUP) && armed_i;

endmodule

// File: rtl/pwrseq_gate.sv
`timescale 1ns/1ps
module pwrseq_gate
    import pwrseq_pkg::*;
(
    input  pwr_state_e state_i,
    input  strobes_t   host_i,
    output strobes_t   mem_o,
    output logic       dq_hiz_o
);
    logic guard;

    assign guard      = is_guarded(state_i);
    assign mem_o.ce_n = host_i.ce_n | guard;
    assign mem_o.we_n = host_i.we_n | guard;
    assign mem_o.oe_n = host_i.oe_n | guard;
    assign dq_hiz_o   = guard | !host_reads(host_i);

endmodule

// File: rtl/supply_fail_guard.sv
`timescale 1ns/1ps
module supply_fail_guard
    import pwrseq_pkg::*;
#(
    parameter int FILT_TICKS    = 4,
    parameter int RECOVER_TICKS = 15_625_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       factory_rst,
    input  logic       vtrip_ok_i,
    input  logic       vsw_ok_i,
    input  logic       host_ce_n_i,
    input  logic       host_we_n_i,
    input  logic       host_oe_n_i,
    output logic       mem_ce_n_o,
    output logic       mem_we_n_o,
    output logic       mem_oe_n_o,
    output logic       dq_hiz_o,
    output logic       bat_sel_o,
    output logic       armed_o,
    output logic [2:0] mode_o
);
    logic                 any_rst;
    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] clean_flags;
    logic                 trip_clean;
    logic                 sw_clean;
    logic                 arm_req;
    logic                 armed;
    pwr_state_e           state;
    strobes_t             host_s;
    strobes_t             mem_s;

    assign any_rst              = rst | factory_rst;
    assign raw_flags[FLAG_TRIP] = vtrip_ok_i;
    assign raw_flags[FLAG_SW]   = vsw_ok_i;
    assign trip_clean           = clean_flags[FLAG_TRIP];
    assign sw_clean             = clean_flags[FLAG_SW];

    pwrseq_lvl_filter #(
        .WIDTH      (NUM_FLAGS),
        .FILT_TICKS (FILT_TICKS)
    ) u_filter (
        .clk     (clk),
        .rst     (any_rst),
        .raw_i   (raw_flags),
        .clean_o (clean_flags)
    );

    pwrseq_seal u_seal (
        .clk         (clk),
        .factory_rst (factory_rst),
        .arm_i       (arm_req),
        .armed_o     (armed)
    );

    pwrseq_fsm #(
        .RECOVER_TICKS (RECOVER_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .factory_rst (factory_rst),
        .trip_ok_i   (trip_clean),
        .sw_ok_i     (sw_clean),
        .armed_i     (armed),
        .state_o     (state),
        .arm_o       (arm_req),
        .bat_sel_o   (bat_sel_o)
    );

    assign host_s.ce_n = host_ce_n_i;
    assign host_s.we_n = host_we_n_i;
    assign host_s.oe_n = host_oe_n_i;

    pwrseq_gate u_gate (
        .state_i  (state),
        .host_i   (host_s),
        .mem_o    (mem_s),
        .dq_hiz_o (dq_hiz_o)
    );

    assign mem_ce_n_o = mem_s.ce_n;
    assign mem_we_n_o = mem_s.we_n;
    assign mem_oe_n_o = mem_s.oe_n;
    assign armed_o    = armed;
    assign mode_o     = state;

endmodule

// File: rtl/pwrseq_checker.sv
`timescale 1ns/1ps
module pwrseq_checker #(
    parameter int RECOVER_TICKS = 15_625_000
) (
    input logic       clk,
    input logic       rst,
    input logic       factory_rst,
    input logic       trip_f,
    input logic       sw_f,
    input logic       mem_ce_n_o,
    input logic       mem_we_n_o,
    input logic       mem_oe_n_o,
    input logic       dq_hiz_o,
    input logic       bat_sel_o,
    input logic       armed_o,
    input logic [2:0] mode_o
);
    logic [31:0] rec_cnt;

    always_ff @(posedge clk) begin
        if (rst || factory_rst) begin
            rec_cnt <= '0;
        end else if (mode_o == 3'd4) begin
            rec_cnt <= rec_cnt + 32'd1;
        end else begin
            rec_cnt <= '0;
        end
    end

    p_guarded_strobes_r3: assert property (@(posedge clk) disable iff (rst || factory_rst)
        (mode_o != 3'd1) |-> (mem_ce_n_o && mem_we_n_o && mem_oe_n_o && dq_hiz_o));

    p_sealed_no_backup_r9: assert property (@(posedge clk) disable iff (factory_rst)
        !armed_o |-> !bat_sel_o);

    p_backup_after_low_sw_r6: assert property (@(posedge clk) disable iff (rst || factory_rst)
        $rose(bat_sel_o) |-> !$past(sw_f));

    p_normal_trip_drop_r5: assert property (@(posedge clk) disable iff (rst || factory_rst)
        (mode_o == 3'd1 && !trip_f) |=> (mode_o == 3'd2));

    p_recover_abort_r8: assert property (@(posedge clk) disable iff (rst || factory_rst)
        (mode_o == 3'd4 && !trip_f) |=> (mode_o == 3'd2));

    p_recover_length_r7: assert property (@(posedge clk) disable iff (rst || factory_rst)
        (mode_o == 3'd1 && rec_cnt != 32'd0) |-> (rec_cnt == RECOVER_TICKS));

    p_armed_sticky_r10: assert property (@(posedge clk) disable iff (factory_rst)
        armed_o |=> armed_o);

endmodule

bind supply_fail_guard pwrseq_checker #(
    .RECOVER_TICKS (RECOVER_TICKS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .factory_rst (factory_rst),
    .trip_f      (trip_clean),
    .sw_f        (sw_clean),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .dq_hiz_o    (dq_hiz_o),
    .bat_sel_o   (bat_sel_o),
    .armed_o     (armed_o),
    .mode_o      (mode_o)
);

// File: tb/supply_fail_guard_tb.sv
`timescale 1ns/1ps
module supply_fail_guard_tb;
    localparam int F = 3;
    localparam int R = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic factory_rst = 1'b1;
    logic vtrip = 1'b0;
    logic vsw = 1'b0;
    logic hce = 1'b1;
    logic hwe = 1'b1;
    logic hoe = 1'b1;
    logic mce, mwe, moe, hiz, bat, armed;
    logic [2:0] mode;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R2";

    // behavioural reference state
    int m_s1[2], m_s2[2], m_f[2], m_run[2];
    int m_state = 0;
    int m_rec = 0;
    bit m_armed = 0;

    always #4 clk = ~clk;

    supply_fail_guard #(.FILT_TICKS(F), .RECOVER_TICKS(R)) u_dut (
        .clk(clk), .rst(rst), .factory_rst(factory_rst),
        .vtrip_ok_i(vtrip), .vsw_ok_i(vsw),
        .host_ce_n_i(hce), .host_we_n_i(hwe), .host_oe_n_i(hoe),
        .mem_ce_n_o(mce), .mem_we_n_o(mwe), .mem_oe_n_o(moe),
        .dq_hiz_o(hiz), .bat_sel_o(bat), .armed_o(armed), .mode_o(mode)
    );

    task automatic model_edge();
        int ins[2];
        ins[0] = vtrip;
        ins[1] = vsw;
        if (factory_rst) begin
            m_armed = 0;
            m_state = 0;
        end else if (rst) begin
            m_state = m_armed ? 2 : 0;
        end
        if (rst || factory_rst) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
            end
            m_rec = 0;
        end else begin
            case (m_state)
                0: if (m_f[0] == 1) begin m_armed = 1; m_state = 4; m_rec = 0; end
                1: if (m_f[0] == 0) m_state = 2;
                2: if (m_f[1] == 0) m_state = 3;
                   else if (m_f[0] == 1) begin m_state = 4; m_rec = 0; end
                3: if (m_f[1] == 1) m_state = 2;
                4: if (m_f[0] == 0) m_state = 2;
                   else if (m_rec == R - 1) m_state = 1;
                   else m_rec++;
                default: m_state = 2;
            endcase
            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] == m_f[i]) m_run[i] = 0;
                else begin
                    m_run[i]++;
                    if (m_run[i] == F) begin m_f[i] = m_s2[i]; m_run[i] = 0; end
                end
                m_s2[i] = m_s1[i];
                m_s1[i] = ins[i];
            end
        end
    endtask

    task automatic chk(string what, logic [2:0] act, logic [2:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit g;
        g = (m_state != 1);
        chk("mode_o", mode, 3'(m_state));
        chk("armed_o", {2'b0, armed}, {2'b0, m_armed});
        chk("bat_sel_o", {2'b0, bat}, {2'b0, 1'(m_state == 3)});
        chk("mem_ce_n_o", {2'b0, mce}, {2'b0, hce | g});
        chk("mem_we_n_o", {2'b0, mwe}, {2'b0, hwe | g});
        chk("mem_oe_n_o", {2'b0, moe}, {2'b0, hoe | g});
        chk("dq_hiz_o", {2'b0, hiz}, {2'b0, g | hce | hoe | !hwe});
    endtask

    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic host(bit c, bit w, bit o);
        hce = c; hwe = w; hoe = o;
    endtask

    initial begin
        // R2: factory reset state
        cur_req = "R2";
        tick(3);
        rst = 0; factory_rst = 0;
        tick(2);
        // R9: sealed, switchover low, host active; backup must stay off
        cur_req = "R9";
        host(0, 0, 1);
        tick(10);
        vsw = 1;
        tick(8);
        vtrip = 1;
        tick(8);
        // R7: recovery window then normal
        cur_req = "R7";
        host(0, 1, 0);
        tick(R + 4);
        // R4: pass-through patterns in normal
        cur_req = "R4";
        host(0, 1, 0); tick(2);
        host(0, 0, 1); tick(2);
        host(0, 0, 0); tick(2);
        host(1, 1, 0); tick(2);
        host(1, 1, 1); tick(2);
        // R1: short glitches rejected
        cur_req = "R1";
        vtrip = 0; tick(1); vtrip = 1; tick(6);
        vtrip = 0; tick(2); vtrip = 1; tick(8);
        // R5: sustained drop during a write
        cur_req = "R5";
        host(0, 0, 1);
        vtrip = 0;
        tick(F + 3);
        // R3: host driving while guarded
        cur_req = "R3";
        host(0, 1, 0); tick(3);
        host(0, 0, 0); tick(3);
        // R6: backup switching
        cur_req = "R6";
        vsw = 0; tick(10);
        vsw = 1; tick(10);
        // R8: abort during recover, then full recovery
        cur_req = "R8";
        vtrip = 1; tick(F + 8);
        vtrip = 0; tick(F + 5);
        vtrip = 1; tick(R + F + 8);
        // R10: ordinary reset keeps arming; factory reset clears it
        cur_req = "R10";
        rst = 1; tick(2); rst = 0;
        tick(4);
        tick(R + 4);
        vsw = 0; vtrip = 0; tick(10);
        factory_rst = 1; tick(2); factory_rst = 0;
        tick(10);
        rst = 1; tick(2); rst = 0;
        tick(5);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule